// File: doc/BRIEF.md
# Hardware Return-Address Stack Controller

This block runs the automatic return stack used on subroutine calls and interrupt entry. The stack occupies a fixed sixteen-byte window of data memory. The block keeps a four-bit pointer into that window. When asked to save a twelve-bit return address, it writes the address as two bytes over two consecutive cycles. When asked to recover one, it reads the two bytes back in the opposite order and presents the rebuilt address together with a one-cycle completion pulse.

The pointer always marks the next free byte. The stack grows downward, so a save moves the pointer down by two and a recovery moves it up by two. Software can place the pointer anywhere in the window through a load port. Pointer arithmetic wraps modulo sixteen. A wrap in either direction sets a sticky flag, which clears only on reset, and the wrap never blocks the transfer. The memory array, instruction decode and program-counter policy belong to the surrounding core.

Top module: `rstack_ctrl`

## Requirements
- R1: After reset the pointer reads 0xF, the wrap flag and the done pulse are low, and no memory strobe is active.
- R2: Every memory access uses the 8-bit address formed by 0x3 in bits 7:4 and a pointer-derived offset in bits 3:0.
- R3: A save request accepted while idle writes the low address byte at the pointer in the next cycle. In the following cycle it writes the high byte, zero-extended from address bits 11:8, at pointer−1. The pointer ends two below its start.
- R4: A recovery request accepted while idle reads the byte at pointer+1 as the high byte, then the byte at pointer+2 as the low byte, in consecutive cycles. The pointer ends two above its start, and the recovered address is {high[3:0], low}.
- R5: The done output is high for exactly one cycle, the cycle after the second byte transfer. The recovered address is valid in that cycle.
- R6: A pointer load while idle sets the pointer to the loaded value on the next edge. A load while a transfer is in progress has no effect.
- R7: When save and recovery are requested in the same idle cycle, the save is performed. A load in that same cycle takes precedence over both, and neither transfer starts.
- R8: Save and recovery requests that arrive while a transfer is in progress are ignored.
- R9: The pointer wraps modulo 16 (0 steps down to 15, 15 steps up to 0). Any wrap sets the wrap flag, which then stays set until reset.
- R10: Each byte transfer lasts one cycle, and the write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Save a return address |
| pull_req | input | 1 | Recover a return address |
| ret_addr | input | 12 | Return address to save |
| ld_en | input | 1 | Load the pointer |
| ld_val | input | 4 | Pointer value to load |
| mem_addr | output | 8 | Data memory byte address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read byte, valid in the same cycle as mem_re |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| pull_addr | output | 12 | Recovered return address |
| sp | output | 4 | Current pointer |
| wrap_flag | output | 1 | Sticky wrap indicator |

## Verification
Three requests can meet in one idle cycle: save, recovery and pointer load. The bench raises them together and judges the result from the memory strobes in the next cycle and from the pointer after completion. Save alone must run when it meets recovery, and a load must beat both. The bench also drives both requests and a load during the first byte of a save. The finished save must leave the pointer exactly two lower, with the load dropped.

// File: rtl/rstack_pkg.sv
package rstack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_PULL_HI,
    ST_PULL_LO
  } seq_st_t;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_DEC,
    STEP_INC
  } step_t;
endpackage

// File: rtl/rstack_ptr.sv
module rstack_ptr
  import rstack_pkg::*;
#(
  parameter int PTR_W = 4,
  parameter logic [PTR_W-1:0] RST_PTR = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_t            step,
  input  logic             ld_en,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W-1:0] ptr,
  output logic             wrap_flag
);
  localparam logic [PTR_W-1:0] PTR_MAX = '1;
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptr_d;
  logic             wrap_d;
  logic             ptr_en;

  always_comb begin
    ptr_d  = ptr;
    wrap_d = wrap_flag;
    ptr_en = 1'b0;
    if (ld_en) begin
      ptr_d  = ld_val;
      ptr_en = 1'b1;
    end else begin
      case (step)
        STEP_DEC: begin
          ptr_d  = ptr - PTR_ONE;
          ptr_en = 1'b1;
          if (ptr == '0) wrap_d = 1'b1;
        end
        STEP_INC: begin
          ptr_d  = ptr + PTR_ONE;
          ptr_en = 1'b1;
          if (ptr == PTR_MAX) wrap_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= RST_PTR;
      wrap_flag <= 1'b0;
    end else begin
      if (ptr_en) ptr <= ptr_d;
      wrap_flag <= wrap_d;
    end
  end

  AST_PTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_DEC && !ld_en) |=> ptr == PTR_W'($past(ptr) - PTR_ONE)); // R3
  AST_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_INC && !ld_en) |=> ptr == PTR_W'($past(ptr) + PTR_ONE)); // R4
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ptr == $past(ld_val)); // R6
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_flag |=> wrap_flag); // R9
endmodule

// File: rtl/rstack_seq.sv
module rstack_seq
  import rstack_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pull_req,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [BYTE_W-1:0] rdata,
  input  logic [PTR_W-1:0]  ptr,
  output step_t             step,
  output logic              ld_ok,
  output logic              mem_we,
  output logic              mem_re,
  output logic [PTR_W-1:0]  mem_off,
  output logic [BYTE_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pull_addr
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  seq_st_t           st_q, st_d;
  logic [ADDR_W-1:0] ret_q, ret_d;
  logic              done_d;

  always_comb begin
    st_d    = st_q;
    ret_d   = ret_q;
    done_d  = 1'b0;
    step    = STEP_NONE;
    ld_ok   = 1'b0;
    mem_we  = 1'b0;
    mem_re  = 1'b0;
    mem_off = ptr;
    wdata   = '0;
    case (st_q)
      ST_IDLE: begin
        if (ld_req)        ld_ok = 1'b1;
        else if (push_req) begin
          st_d  = ST_PUSH_LO;
          ret_d = ret_addr;
        end else if (pull_req) st_d = ST_PULL_HI;
      end
      ST_PUSH_LO: begin
        mem_we = 1'b1;
        wdata  = ret_q[BYTE_W-1:0];
        step   = STEP_DEC;
        st_d   = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        mem_we = 1'b1;
        wdata  = {{(BYTE_W-HI_W){1'b0}}, ret_q[ADDR_W-1:BYTE_W]};
        step   = STEP_DEC;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_PULL_HI: begin
        mem_re  = 1'b1;
        mem_off = ptr + PTR_ONE;
        step    = STEP_INC;
        ret_d[ADDR_W-1:BYTE_W] = rdata[HI_W-1:0];
        st_d    = ST_PULL_LO;
      end
      ST_PULL_LO: begin
        mem_re  = 1'b1;
        mem_off = ptr + PTR_ONE;
        step    = STEP_INC;
        ret_d[BYTE_W-1:0] = rdata;
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ret_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      done  <= done_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign pull_addr = ret_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10
  AST_DONE_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st_q) == ST_PUSH_HI || $past(st_q) == ST_PULL_LO)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH_LO) |=> (st_q == ST_PUSH_HI)); // R3
  AST_PULL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PULL_HI) |=> (st_q == ST_PULL_LO)); // R4
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ok); // R6
endmodule

// File: rtl/rstack_ctrl.sv
module rstack_ctrl
  import rstack_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 4,
  parameter int MEM_AW = 8,
  parameter logic [MEM_AW-PTR_W-1:0] WIN_BASE = (MEM_AW-PTR_W)'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pull_req,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              ld_en,
  input  logic [PTR_W-1:0]  ld_val,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pull_addr,
  output logic [PTR_W-1:0]  sp,
  output logic              wrap_flag
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  step_t            step;
  logic             ld_ok;
  logic [PTR_W-1:0] mem_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rstack_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .PTR_W(PTR_W)) i_seq (
    .clk(clk), .rst_n(rst_int_n), .push_req(push_req), .pull_req(pull_req),
    .ld_req(ld_en), .ret_addr(ret_addr), .rdata(mem_rdata), .ptr(sp),
    .step(step), .ld_ok(ld_ok), .mem_we(mem_we), .mem_re(mem_re),
    .mem_off(mem_off), .wdata(mem_wdata), .busy(busy), .done(done),
    .pull_addr(pull_addr)
  );

  rstack_ptr #(.PTR_W(PTR_W)) i_ptr (
    .clk(clk), .rst_n(rst_int_n), .step(step), .ld_en(ld_ok),
    .ld_val(ld_val), .ptr(sp), .wrap_flag(wrap_flag)
  );

  assign mem_addr = {WIN_BASE, mem_off};

  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_we || mem_re) |-> mem_addr[MEM_AW-1:PTR_W] == WIN_BASE); // R2
endmodule

// File: tb/test_rstack_ctrl.sv
`timescale 1ns/1ps
module test_rstack_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_req, pull_req, ld_en;
  logic [11:0] ret_addr;
  logic [3:0]  ld_val;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_re, busy, done, wrap_flag;
  logic [11:0] pull_addr;
  logic [3:0]  sp;

  logic [7:0]  bmem [16];
  logic [7:0]  mmem [16];
  logic [3:0]  mptr;
  logic        mwrap;
  int          checks = 0;
  int          failures = 0;

  always #4 clk = ~clk;

  rstack_ctrl i_rstack_ctrl (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pull_req(pull_req),
    .ret_addr(ret_addr), .ld_en(ld_en), .ld_val(ld_val), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pull_addr(pull_addr),
    .sp(sp), .wrap_flag(wrap_flag)
  );

  assign mem_rdata = bmem[mem_addr[3:0]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[3:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] win(input logic [3:0] off);
    return {4'h3, off};
  endfunction

  task automatic model_push(input logic [11:0] a);
    mmem[mptr] = a[7:0];
    if (mptr == 4'd0) mwrap = 1'b1;
    mptr = mptr - 4'd1;
    mmem[mptr] = {4'h0, a[11:8]};
    if (mptr == 4'd0) mwrap = 1'b1;
    mptr = mptr - 4'd1;
  endtask

  task automatic do_push(input logic [11:0] a);
    logic [3:0] p = mptr;
    push_req = 1'b1; ret_addr = a;
    @(posedge clk); @(negedge clk);
    push_req = 1'b0;
    chk(mem_we && !mem_re && mem_addr == win(p), "R3 lo addr", {mem_we, mem_re, mem_addr}, {2'b10, win(p)});
    chk(mem_wdata == a[7:0], "R3 lo data", mem_wdata, a[7:0]);
    chk(busy, "R5 busy", busy, 1);
    @(negedge clk);
    chk(mem_we && mem_addr == win(p - 4'd1), "R3 hi addr", mem_addr, win(p - 4'd1));
    chk(mem_wdata == {4'h0, a[11:8]}, "R3 hi data", mem_wdata, {4'h0, a[11:8]});
    chk(!done, "R5 no early done", done, 0);
    @(negedge clk);
    model_push(a);
    chk(done && !mem_we, "R5 done", done, 1);
    chk(sp == mptr, "R3 pointer", sp, mptr);
    chk(wrap_flag == mwrap, "R9 wrap", wrap_flag, mwrap);
    @(negedge clk);
    chk(!done, "R5 pulse width", done, 0);
  endtask

  task automatic do_pull();
    logic [3:0]  p = mptr;
    logic [11:0] exp = {mmem[p + 4'd1][3:0], mmem[p + 4'd2]};
    pull_req = 1'b1;
    @(posedge clk); @(negedge clk);
    pull_req = 1'b0;
    chk(mem_re && !mem_we && mem_addr == win(p + 4'd1), "R4 hi read", {mem_re, mem_we, mem_addr}, {2'b10, win(p + 4'd1)});
    @(negedge clk);
    chk(mem_re && mem_addr == win(p + 4'd2), "R4 lo read", mem_addr, win(p + 4'd2));
    @(negedge clk);
    if (p >= 4'd14) mwrap = 1'b1;
    mptr = p + 4'd2;
    chk(done, "R5 done pull", done, 1);
    chk(pull_addr == exp, "R4 address", pull_addr, exp);
    chk(sp == mptr, "R4 pointer", sp, mptr);
    chk(wrap_flag == mwrap, "R9 wrap", wrap_flag, mwrap);
  endtask

  task automatic do_load(input logic [3:0] v);
    ld_en = 1'b1; ld_val = v;
    @(posedge clk); @(negedge clk);
    ld_en = 1'b0;
    mptr = v;
    chk(sp == v && !mem_we && !mem_re, "R6 load", sp, v);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin
      bmem[i] = 8'(i * 7);
      mmem[i] = 8'(i * 7);
    end
    rst_n = 1'b0; push_req = 0; pull_req = 0; ld_en = 0; ret_addr = 0; ld_val = 0;
    mptr = 4'hF; mwrap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp == 4'hF, "R1 pointer", sp, 4'hF);
    chk(!wrap_flag && !done && !mem_we && !mem_re && !busy, "R1 idle", {wrap_flag, done, mem_we, mem_re, busy}, 0);

    // R2 R3 R4 R5 directed round trip
    do_push(12'hA5C);
    do_pull();
    chk(pull_addr == 12'hA5C, "R4 round trip", pull_addr, 12'hA5C);

    // R7 push and pull together: push wins
    push_req = 1'b1; pull_req = 1'b1; ret_addr = 12'h3E1;
    @(posedge clk); @(negedge clk);
    push_req = 0; pull_req = 0;
    chk(mem_we && !mem_re, "R7 push priority", {mem_we, mem_re}, 2'b10);
    repeat (2) @(negedge clk);
    model_push(12'h3E1);
    chk(sp == mptr, "R7 pointer", sp, mptr);

    // R7 load beats both
    ld_en = 1; ld_val = 4'h9; push_req = 1; pull_req = 1;
    @(posedge clk); @(negedge clk);
    ld_en = 0; push_req = 0; pull_req = 0;
    chk(!mem_we && !mem_re && !busy, "R7 load wins", {mem_we, mem_re, busy}, 0);
    chk(sp == 4'h9, "R7 load value", sp, 4'h9);
    mptr = 4'h9;

    // R6 R8 requests and load during a transfer are ignored
    push_req = 1; ret_addr = 12'h7B2;
    @(posedge clk); @(negedge clk);
    push_req = 0; pull_req = 1; ld_en = 1; ld_val = 4'h2;
    @(negedge clk);
    pull_req = 0; ld_en = 0;
    @(negedge clk);
    model_push(12'h7B2);
    chk(done && sp == mptr, "R6 R8 busy ignore", sp, mptr);
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R8 no queued request", busy, 0);

    // R9 wrap downward then upward
    do_load(4'h1);
    do_push(12'hF0F);
    chk(wrap_flag, "R9 sticky after down wrap", wrap_flag, 1);
    do_pull();
    do_load(4'h5);
    chk(wrap_flag, "R9 still sticky", wrap_flag, 1);

    // random mix, R3 R4 R6 R10
    for (int n = 0; n < 300; n++) begin
      int r = $urandom % 8;
      if (r < 4) do_push(12'($urandom));
      else if (r < 7) do_pull();
      else do_load(4'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule